// File: doc/BRIEF.md
# Modulo Base-Plus-Displacement Address Generator

This block forms the effective address of a memory operand from a base register and a displacement register. An 8-bit immediate can be added as a third term. In the two stepping modes, the displacement is moved down before use or up after use by the operand size. The top five bits of every displacement word hold a length code n. Stepping changes only the low n bits of the displacement, so a buffer of 2^n bytes wraps around on itself. This allows circular buffers and filter delay lines to run without any range checks in software.

The block is purely combinational. The caller presents the base, the displacement word, the mode, the immediate and the step size. In the same cycle, the caller reads back the effective address and the displacement word to write back into the register. Memory access and decoding of the operand size are done elsewhere.

Top module: `modaddr_gen`

## Requirements
- R1: The length code is the unsigned value of displacement bits [31:27], with bit 31 as its MSB. A code from 1 to 27 gives a wrap length n equal to the code, which is a circular range of 2^n bytes.
- R2: A length code of 0, and any code from 28 to 31, gives the full length n = 27.
- R3: In mode 0 (direct), the effective address is base + disp[26:0], and the returned displacement equals the input displacement. The length code takes no part in the sum.
- R4: In mode 1 (direct plus immediate), the effective address is base + disp[26:0] + the zero-extended 8-bit immediate, and the returned displacement equals the input displacement.
- R5: In mode 2 (predecrement), the low n bits of the displacement are reduced by the step modulo 2^n. The effective address uses the updated displacement.
- R6: In mode 3 (postincrement), the effective address uses the original displacement. The low n bits are increased by the step modulo 2^n.
- R7: Displacement bits [26:n] and the length code bits [31:27] are always returned unchanged.
- R8: The step select gives 1 byte for code 0, 2 bytes for code 1, and 4 bytes for codes 2 and 3.
- R9: The effective address sum wraps modulo 2^32.
- R10: The immediate has no effect on either output in modes 0, 2 and 3.
- R11: Both outputs follow the inputs within the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| base_i | input | 32 | Base register value |
| disp_i | input | 32 | Displacement word: length code in [31:27], offset in [26:0] |
| mode_i | input | 2 | 0 direct, 1 direct plus immediate, 2 predecrement, 3 postincrement |
| imm_i | input | 8 | Unsigned immediate added in mode 1 |
| step_i | input | 2 | Step select: 1, 2, 4, 4 bytes |
| ea_o | output | 32 | Effective address |
| disp_o | output | 32 | Displacement word to write back |

## Verification
The assertions assume that all inputs hold stable, 2-state values between changes. They also assume that the step select stays within the three documented sizes whenever the wrap distance is checked. Code 3 is treated as a 4-byte step and gets no special handling. The directed stimulus drives one complete request at a time on the falling clock edge and samples after it has settled. It covers every length code from 0 to 31 in both stepping modes, including offsets that sit exactly on a wrap boundary, so no half-updated input combination ever reaches the checker.

// File: rtl/modaddr_pkg.sv
package modaddr_pkg;

    typedef enum logic [1:0] {
        AM_DIRECT     = 2'd0,
        AM_DIRECT_IMM = 2'd1,
        AM_PREDEC     = 2'd2,
        AM_POSTINC    = 2'd3
    } am_mode_e;

    typedef struct packed {
        logic is_pre;
        logic is_post;
        logic add_imm;
    } upd_ctl_t;

    localparam int STEP_W = 3;

    function automatic upd_ctl_t decode_mode(input am_mode_e m);
        upd_ctl_t c;
        c.is_pre  = (m == AM_PREDEC);
        c.is_post = (m == AM_POSTINC);
        c.add_imm = (m == AM_DIRECT_IMM);
        return c;
    endfunction

    function automatic logic [STEP_W-1:0] step_bytes(input logic [1:0] sel);
        case (sel)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/modaddr_len_decode.sv
module modaddr_len_decode #(
    parameter int LEN_W  = 5,
    parameter int DISP_W = 27
) (
    input  logic [LEN_W-1:0]  code_i,
    output logic [DISP_W-1:0] mask_o
);
    localparam int N_W = $clog2(DISP_W + 1) + 1;

    logic [N_W-1:0] n_eff;

    always_comb begin
        if (code_i == '0 || int'(code_i) > DISP_W)
            n_eff = N_W'(DISP_W);
        else
            n_eff = N_W'(code_i);
    end

    for (genvar i = 0; i < DISP_W; i++) begin : g_mask
        assign mask_o[i] = (int'(n_eff) > i);
    end
endmodule

// File: rtl/modaddr_disp_step.sv
module modaddr_disp_step
    import modaddr_pkg::*;
#(
    parameter int DISP_W = 27
) (
    input  logic [DISP_W-1:0] off_i,
    input  logic [DISP_W-1:0] mask_i,
    input  logic [STEP_W-1:0] step_i,
    input  upd_ctl_t          ctl_i,
    output logic [DISP_W-1:0] off_o
);
    logic [DISP_W-1:0] step_ext;
    logic [DISP_W-1:0] moved;

    assign step_ext = {{(DISP_W-STEP_W){1'b0}}, step_i};
    assign moved    = ctl_i.is_post ? (off_i + step_ext) : (off_i - step_ext);

    always_comb begin
        if (ctl_i.is_pre || ctl_i.is_post)
            off_o = (off_i & ~mask_i) | (moved & mask_i);
        else
            off_o = off_i;
    end
endmodule

// File: rtl/modaddr_ea_sum.sv
module modaddr_ea_sum #(
    parameter int ADDR_W     = 32,
    parameter int DISP_W     = 27,
    parameter int IMM_W      = 8,
    parameter bit IMM_SIGNED = 1'b0
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [DISP_W-1:0] off_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              add_imm_i,
    output logic [ADDR_W-1:0] ea_o
);
    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] imm_ext;

    assign off_ext = {{(ADDR_W-DISP_W){1'b0}}, off_i};

    if (IMM_SIGNED) begin : g_imm_sx
        assign imm_ext = add_imm_i ? {{(ADDR_W-IMM_W){imm_i[IMM_W-1]}}, imm_i} : '0;
    end else begin : g_imm_zx
        assign imm_ext = add_imm_i ? {{(ADDR_W-IMM_W){1'b0}}, imm_i} : '0;
    end

    assign ea_o = base_i + off_ext + imm_ext;
endmodule

// File: rtl/modaddr_gen.sv
module modaddr_gen
    import modaddr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 5,
    parameter int IMM_W      = 8,
    parameter bit IMM_SIGNED = 1'b0
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] disp_i,
    input  logic [1:0]        mode_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [1:0]        step_i,
    output logic [ADDR_W-1:0] ea_o,
    output logic [ADDR_W-1:0] disp_o
);
    localparam int DISP_W = ADDR_W - LEN_W;

    logic [LEN_W-1:0]  len_code;
    logic [DISP_W-1:0] off_cur;
    logic [DISP_W-1:0] off_new;
    logic [DISP_W-1:0] off_use;
    logic [DISP_W-1:0] wrap_mask;
    logic [STEP_W-1:0] step_amt;
    upd_ctl_t          ctl;

    assign len_code = disp_i[ADDR_W-1 -: LEN_W];
    assign off_cur  = disp_i[DISP_W-1:0];
    assign ctl      = decode_mode(am_mode_e'(mode_i));
    assign step_amt = step_bytes(step_i);

    modaddr_len_decode #(
        .LEN_W  (LEN_W),
        .DISP_W (DISP_W)
    ) u_len (
        .code_i (len_code),
        .mask_o (wrap_mask)
    );

    modaddr_disp_step #(
        .DISP_W (DISP_W)
    ) u_step (
        .off_i  (off_cur),
        .mask_i (wrap_mask),
        .step_i (step_amt),
        .ctl_i  (ctl),
        .off_o  (off_new)
    );

    assign off_use = ctl.is_pre ? off_new : off_cur;

    modaddr_ea_sum #(
        .ADDR_W     (ADDR_W),
        .DISP_W     (DISP_W),
        .IMM_W      (IMM_W),
        .IMM_SIGNED (IMM_SIGNED)
    ) u_sum (
        .base_i    (base_i),
        .off_i     (off_use),
        .imm_i     (imm_i),
        .add_imm_i (ctl.add_imm),
        .ea_o      (ea_o)
    );

    assign disp_o = {len_code, off_new};
endmodule

// File: rtl/modaddr_gen_chk.sv
module modaddr_gen_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 5,
    parameter int IMM_W  = 8
) (
    input logic [ADDR_W-1:0] base_i,
    input logic [ADDR_W-1:0] disp_i,
    input logic [1:0]        mode_i,
    input logic [IMM_W-1:0]  imm_i,
    input logic [1:0]        step_i,
    input logic [ADDR_W-1:0] ea_o,
    input logic [ADDR_W-1:0] disp_o
);
    localparam int DISP_W = ADDR_W - LEN_W;

    logic [DISP_W-1:0] keep;
    logic [DISP_W-1:0] delta;
    logic [DISP_W-1:0] stp;
    int                len;

    always_comb begin
        len = int'(disp_i[ADDR_W-1 -: LEN_W]);
        if (len == 0 || len > DISP_W) len = DISP_W;
        keep = '0;
        for (int i = 0; i < DISP_W; i++)
            if (i < len) keep[i] = 1'b1;
        stp   = (step_i == 2'd0) ? DISP_W'(1) : (step_i == 2'd1) ? DISP_W'(2) : DISP_W'(4);
        delta = (disp_o[DISP_W-1:0] - disp_i[DISP_W-1:0]) & keep;
    end

    always_comb begin
        AST_CODE_KEPT: assert (disp_o[ADDR_W-1 -: LEN_W] == disp_i[ADDR_W-1 -: LEN_W])
            else $error("length code altered"); // R7
        AST_UPPER_KEPT: assert (((disp_o[DISP_W-1:0] ^ disp_i[DISP_W-1:0]) & ~keep) == '0)
            else $error("bits above wrap length altered"); // R7
        if (mode_i[1] == 1'b0) begin
            AST_DIRECT_HOLD: assert (disp_o == disp_i)
                else $error("direct mode changed displacement"); // R3
        end
        if (mode_i == 2'd0) begin
            AST_DIRECT_EA: assert (ea_o == base_i + {{LEN_W{1'b0}}, disp_i[DISP_W-1:0]})
                else $error("direct address wrong"); // R3
        end
        if (mode_i == 2'd1) begin
            AST_IMM_EA: assert (ea_o == base_i + {{LEN_W{1'b0}}, disp_i[DISP_W-1:0]}
                                     + {{(ADDR_W-IMM_W){1'b0}}, imm_i})
                else $error("immediate address wrong"); // R4
        end
        if (mode_i == 2'd2) begin
            AST_PRE_EA: assert (ea_o == base_i + {{LEN_W{1'b0}}, disp_o[DISP_W-1:0]})
                else $error("predecrement address not from updated offset"); // R5
            AST_PRE_DIST: assert (delta == ((-stp) & keep))
                else $error("predecrement distance wrong"); // R5
        end
        if (mode_i == 2'd3) begin
            AST_POST_EA: assert (ea_o == base_i + {{LEN_W{1'b0}}, disp_i[DISP_W-1:0]})
                else $error("postincrement address not from original offset"); // R6
            AST_POST_DIST: assert (delta == (stp & keep))
                else $error("postincrement distance wrong"); // R6
        end
    end
endmodule

bind modaddr_gen modaddr_gen_chk #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .IMM_W  (IMM_W)
) u_chk (
    .base_i (base_i),
    .disp_i (disp_i),
    .mode_i (mode_i),
    .imm_i  (imm_i),
    .step_i (step_i),
    .ea_o   (ea_o),
    .disp_o (disp_o)
);

// File: tb/modaddr_gen_bench.sv
module modaddr_gen_bench;
    logic        clk = 1'b0;
    logic [31:0] base_i = '0;
    logic [31:0] disp_i = '0;
    logic [1:0]  mode_i = '0;
    logic [7:0]  imm_i  = '0;
    logic [1:0]  step_i = '0;
    logic [31:0] ea_o;
    logic [31:0] disp_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    modaddr_gen u_modaddr_gen (
        .base_i (base_i),
        .disp_i (disp_i),
        .mode_i (mode_i),
        .imm_i  (imm_i),
        .step_i (step_i),
        .ea_o   (ea_o),
        .disp_o (disp_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference built from the requirement text.
    function automatic void model(input logic [31:0] b, input logic [31:0] d, input logic [1:0] m,
                                  input logic [7:0] im, input logic [1:0] s,
                                  output logic [31:0] ea, output logic [31:0] dout);
        int          n;
        logic [26:0] mk;
        logic [26:0] off;
        logic [26:0] st;
        n = int'(d[31:27]);
        if (n == 0 || n > 27) n = 27;
        mk  = 27'((64'd1 << n) - 1);
        off = d[26:0];
        st  = (s == 2'd0) ? 27'd1 : (s == 2'd1) ? 27'd2 : 27'd4;
        dout = d;
        case (m)
            2'd0: ea = b + {5'd0, off};
            2'd1: ea = b + {5'd0, off} + {24'd0, im};
            2'd2: begin
                dout[26:0] = (off & ~mk) | ((off - st) & mk);
                ea = b + {5'd0, dout[26:0]};
            end
            default: begin
                dout[26:0] = (off & ~mk) | ((off + st) & mk);
                ea = b + {5'd0, off};
            end
        endcase
    endfunction

    task automatic apply(input logic [31:0] b, input logic [31:0] d, input logic [1:0] m,
                         input logic [7:0] im, input logic [1:0] s);
        @(negedge clk);
        base_i = b; disp_i = d; mode_i = m; imm_i = im; step_i = s;
        #1;
    endtask

    task automatic run_model(input string req, input logic [31:0] b, input logic [31:0] d,
                             input logic [1:0] m, input logic [7:0] im, input logic [1:0] s);
        logic [31:0] e_ea;
        logic [31:0] e_d;
        model(b, d, m, im, s, e_ea, e_d);
        apply(b, d, m, im, s);
        check({req, " ea"}, ea_o, e_ea);
        check({req, " disp"}, disp_o, e_d);
    endtask

    task automatic t_idle;
        apply(32'h0, 32'h0, 2'd0, 8'h0, 2'd0);
        check("R3 idle ea", ea_o, 32'h0);
        check("R3 idle disp", disp_o, 32'h0);
    endtask

    task automatic t_direct;
        apply(32'h0000_1000, 32'hF800_0010, 2'd0, 8'h55, 2'd2);
        check("R3 code excluded from sum", ea_o, 32'h0000_1010);
        check("R3 disp unchanged", disp_o, 32'hF800_0010);
        apply(32'hFFFF_FFF0, 32'h0000_0020, 2'd0, 8'h00, 2'd0);
        check("R9 address wrap", ea_o, 32'h0000_0010);
    endtask

    task automatic t_imm;
        apply(32'h0000_0100, {5'd3, 27'h5}, 2'd1, 8'hFF, 2'd0);
        check("R4 three-term sum", ea_o, 32'h0000_0204);
        check("R4 disp unchanged", disp_o, {5'd3, 27'h5});
    endtask

    task automatic t_imm_ignored;
        logic [31:0] ea0;
        logic [31:0] d0;
        for (int m = 0; m < 4; m++) begin
            if (m == 1) continue;
            apply(32'h2000_0000, {5'd6, 27'h3F}, 2'(m), 8'h00, 2'd1);
            ea0 = ea_o; d0 = disp_o;
            apply(32'h2000_0000, {5'd6, 27'h3F}, 2'(m), 8'hAA, 2'd1);
            check("R10 imm ignored ea", ea_o, ea0);
            check("R10 imm ignored disp", disp_o, d0);
        end
    endtask

    task automatic t_post_wrap;
        apply(32'h0001_0000, {5'd10, 27'h7FF}, 2'd3, 8'h00, 2'd0);
        check("R6 post ea original", ea_o, 32'h0001_07FF);
        check("R1 R6 1024-byte wrap", disp_o, {5'd10, 27'h400});
    endtask

    task automatic t_pre_wrap;
        apply(32'h0001_0000, {5'd10, 27'h400}, 2'd2, 8'h00, 2'd2);
        check("R5 pre wrap disp", disp_o, {5'd10, 27'h7FC});
        check("R5 pre ea updated", ea_o, 32'h0001_07FC);
    endtask

    task automatic t_full_len;
        apply(32'h0, {5'd0, 27'h7FF_FFFF}, 2'd3, 8'h00, 2'd1);
        check("R2 code 0 full wrap", disp_o, {5'd0, 27'h1});
        apply(32'h0, {5'd31, 27'h7FF_FFFF}, 2'd3, 8'h00, 2'd1);
        check("R2 code 31 clamped", disp_o, {5'd31, 27'h1});
        apply(32'h0, {5'd28, 27'h0}, 2'd2, 8'h00, 2'd0);
        check("R2 code 28 clamped", disp_o, {5'd28, 27'h7FF_FFFF});
        apply(32'h0, {5'd27, 27'h7FF_FFFE}, 2'd3, 8'h00, 2'd1);
        check("R1 code 27", disp_o, {5'd27, 27'h0});
    endtask

    task automatic t_steps;
        logic [26:0] exp_off[4] = '{27'h101, 27'h102, 27'h104, 27'h104};
        for (int s = 0; s < 4; s++) begin
            apply(32'h0, {5'd20, 27'h100}, 2'd3, 8'h00, 2'(s));
            check("R8 step size", disp_o, {5'd20, exp_off[s]});
        end
    endtask

    task automatic t_high_keep;
        apply(32'h0, {5'd4, 27'h123_45FE}, 2'd3, 8'h00, 2'd2);
        check("R7 upper bits kept", disp_o, {5'd4, 27'h123_45F2});
        apply(32'h0, {5'd1, 27'h555_5555}, 2'd2, 8'h00, 2'd0);
        check("R7 one-bit window", disp_o, {5'd1, 27'h555_5554});
    endtask

    task automatic t_sweep;
        for (int c = 0; c < 32; c++) begin
            for (int m = 2; m < 4; m++) begin
                run_model("R11 same-cycle sweep", 32'hC000_0000 + 32'(c * 16),
                          {5'(c), 27'h155_5AA0 ^ 27'(c * 3)}, 2'(m), 8'h3C, 2'(c % 4));
            end
        end
        run_model("R4 sweep", 32'h7FFF_FF00, {5'd9, 27'h7FF_FF80}, 2'd1, 8'h90, 2'd0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_idle;
        t_direct;
        t_imm;
        t_imm_ignored;
        t_post_wrap;
        t_pre_wrap;
        t_full_len;
        t_steps;
        t_high_keep;
        t_sweep;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule